// File: doc/BRIEF.md
# Timer Status Flags with Read-Before-Clear

This block is the status register of a four-channel capture/compare timer. It keeps four per-channel event flags and one counter-overflow flag in a single byte that the processor reads and writes over a simple register port. A separate strobe sets each flag. The strobe is a single-cycle pulse that the timer's edge detectors or match comparators produce outside this block. For the channel flags, the mode input chooses which strobe family counts. In capture mode it is the input-edge strobes. In compare mode or PWM mode it is the counter-match strobes.

Software clears a flag by reading the register and then writing 0 to that bit. Each bit keeps a marker that records whether the last read returned 1. A write of 0 clears only those bits whose marker is set, and every write consumes the markers. A flag that rises after software sampled it is therefore never lost to a stale clear.

Top module: `tmr_status_flags`

## Requirements
- R1: While `rst` is high at a clock edge, all flags and markers are cleared, so `rd_data` reads 8'h70 in the following cycle.
- R2: Bits 6:4 of `rd_data` always read 1, and writes have no effect on them.
- R3: With `mode` = 2'b00 (capture), a pulse on `edge_stb[i]` sets channel flag i (bit i, with A..D on bits 0..3) at the next edge, and `match_stb` has no effect.
- R4: With `mode` = 2'b01 (compare) or 2'b10 or 2'b11 (PWM), a pulse on `match_stb[i]` sets channel flag i at the next edge, and `edge_stb` has no effect.
- R5: A pulse on `ovf_stb` sets bit 7 at the next edge, whatever the mode.
- R6: Writing 1 to a flag bit leaves that flag unchanged.
- R7: A write of 0 to a flag bit clears it only if the most recent read (a cycle with `rd_en` high) saw that bit as 1. A flag that was read as 0, set later and then written 0 stays 1. After a write, no bit can be cleared again until another read.
- R8: If a set strobe and a qualifying clear write hit the same bit in the same cycle, the flag ends up 1.
- R9: When `rd_en` and `wr_en` are high in the same cycle, the write uses the markers from the earlier read, and the markers are then reloaded from the value read in this cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 capture, 01 compare, 10/11 PWM |
| edge_stb | input | 4 | Per-channel input-edge strobes |
| match_stb | input | 4 | Per-channel counter-match strobes |
| ovf_stb | input | 1 | Counter overflow strobe |
| rd_en | input | 1 | Register read in this cycle |
| wr_en | input | 1 | Register write in this cycle |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Current register value |

## Verification
The bench targets the lost-event case: a flag that was read as 0, set afterwards and then written 0 must survive. A design that clears on any write of 0 would drop it. A set strobe that coincides with a qualifying clear is also driven, and a design where clear has priority would show 0 there. Write-without-read sequences and simultaneous read/write cycles are covered too. These catch a marker that is never consumed or that is updated in the wrong order. Random strobes in every mode catch a mode decoder that lets the wrong strobe family through.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
    localparam int NUM_CH   = 4;
    localparam int REG_W    = 8;
    localparam int OVF_BIT  = 7;
    localparam logic [2:0] PAD_ONES = 3'b111;

    typedef enum logic [1:0] {
        MODE_CAPTURE = 2'b00,
        MODE_COMPARE = 2'b01,
        MODE_PWM     = 2'b10,
        MODE_PWM2    = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic flag;
        logic mark;
    } flag_state_t;
endpackage

// File: rtl/tsf_evt_sel.sv
module tsf_evt_sel
    import tsf_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic [1:0]    mode,
    input  logic [CH-1:0] edge_stb,
    input  logic [CH-1:0] match_stb,
    output logic [CH-1:0] set_stb
);
    tmr_mode_e mode_e;

    always_comb begin
        mode_e = tmr_mode_e'(mode);
    end

    for (genvar i = 0; i < CH; i++) begin : g_sel
        always_comb begin
            if (mode_e == MODE_CAPTURE) set_stb[i] = edge_stb[i];
            else                        set_stb[i] = match_stb[i];
        end
    end
endmodule

// File: rtl/tsf_flag_cell.sv
module tsf_flag_cell
    import tsf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    flag_state_t st_d, st_q;
    logic        clr_ok;

    always_comb begin
        st_d   = st_q;
        clr_ok = wr_i && !wbit_i && st_q.mark;
        st_d.flag = set_i || (st_q.flag && !clr_ok);
        if (rd_i)      st_d.mark = st_q.flag;
        else if (wr_i) st_d.mark = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o); // R8
    AST_CLR_NEEDS_MARK: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !(wr_i && !wbit_i && st_q.mark)) |=> flag_o); // R7
    AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wbit_i && flag_o) |=> flag_o); // R6
    AST_WRITE_EATS_MARK: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !rd_i) |=> !st_q.mark); // R7
endmodule

// File: rtl/tmr_status_flags.sv
module tmr_status_flags
    import tsf_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic [CH-1:0] edge_stb,
    input  logic [CH-1:0] match_stb,
    input  logic          ovf_stb,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);
    localparam int NFLAG = CH + 1;

    logic [CH-1:0]    ch_set;
    logic [NFLAG-1:0] set_all;
    logic [NFLAG-1:0] wbits;
    logic [NFLAG-1:0] flags;

    tsf_evt_sel #(.CH(CH)) u_sel (
        .mode      (mode),
        .edge_stb  (edge_stb),
        .match_stb (match_stb),
        .set_stb   (ch_set)
    );

    always_comb begin
        set_all = {ovf_stb, ch_set};
        wbits   = {wr_data[OVF_BIT], wr_data[CH-1:0]};
    end

    for (genvar b = 0; b < NFLAG; b++) begin : g_bit
        tsf_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_all[b]),
            .rd_i   (rd_en),
            .wr_i   (wr_en),
            .wbit_i (wbits[b]),
            .flag_o (flags[b])
        );
    end

    always_comb begin
        rd_data = {flags[CH], PAD_ONES, flags[CH-1:0]};
    end

    AST_RESET_VALUE: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h70)); // R1
    AST_OVF_SETS: assert property (@(posedge clk) disable iff (rst)
        ovf_stb |=> rd_data[OVF_BIT]); // R5
    for (genvar c = 0; c < CH; c++) begin : g_chk
        AST_CAP_SETS: assert property (@(posedge clk) disable iff (rst)
            (mode == 2'b00 && edge_stb[c]) |=> rd_data[c]); // R3
        AST_CMP_SETS: assert property (@(posedge clk) disable iff (rst)
            (mode != 2'b00 && match_stb[c]) |=> rd_data[c]); // R4
        AST_CAP_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
            (mode == 2'b00 && !edge_stb[c] && !rd_data[c]) |=> !rd_data[c]); // R3
        AST_CMP_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
            (mode != 2'b00 && !match_stb[c] && !rd_data[c]) |=> !rd_data[c]); // R4
    end
endmodule

// File: tb/tmr_status_flags_test.sv
`timescale 1ns/1ps
module tmr_status_flags_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [3:0] edge_stb = '0;
    logic [3:0] match_stb = '0;
    logic       ovf_stb = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    logic [4:0] m_flag = '0;
    logic [4:0] m_mark = '0;

    always #2.5 clk = ~clk;

    tmr_status_flags uut (
        .clk(clk), .rst(rst), .mode(mode), .edge_stb(edge_stb),
        .match_stb(match_stb), .ovf_stb(ovf_stb), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [7:0] expect_byte(logic [4:0] f);
        return {f[4], 3'b111, f[3:0]};
    endfunction

    function automatic logic [4:0] next_flags(logic [4:0] f, logic [4:0] mk,
            logic [1:0] md, logic [3:0] es, logic [3:0] ms, logic ov,
            logic we, logic [7:0] wd);
        logic [4:0] set, wb, clr;
        set = {ov, (md == 2'b00) ? es : ms};
        wb  = {wd[7], wd[3:0]};
        clr = we ? (~wb & mk) : 5'b0;
        return set | (f & ~clr);
    endfunction

    task automatic check(string rq, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // drive at negedge, check current state, then advance model one edge
    task automatic step(string rq, logic [1:0] md, logic [3:0] es, logic [3:0] ms,
            logic ov, logic rd, logic we, logic [7:0] wd);
        mode = md; edge_stb = es; match_stb = ms; ovf_stb = ov;
        rd_en = rd; wr_en = we; wr_data = wd;
        #1;
        check(rq, rd_data, expect_byte(m_flag));
        @(posedge clk);
        #0.5;
        if (rst) begin
            m_flag = '0; m_mark = '0;
        end else begin
            logic [4:0] nf;
            nf = next_flags(m_flag, m_mark, md, es, ms, ov, we, wd);
            if (rd) m_mark = m_flag;
            else if (we) m_mark = '0;
            m_flag = nf;
        end
        @(negedge clk);
    endtask

    task automatic idle(string rq);
        step(rq, 2'b00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: rd_data=%h expected=done", rd_data);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'h5eed);
        @(negedge clk);
        step("R1", 2'b00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00); // under reset
        rst = 1'b0;
        idle("R1");
        // R2: writes to pad bits
        step("R2", 2'b00, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 8'h00);
        idle("R2");
        // R3: capture mode, match ignored, edge sets
        step("R3", 2'b00, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0, 8'h00);
        idle("R3");
        step("R3", 2'b00, 4'h5, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00);
        idle("R3");
        // R5 overflow
        step("R5", 2'b01, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 8'h00);
        idle("R5");
        // R6: read then write all ones keeps flags
        step("R6", 2'b00, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 8'h00);
        step("R6", 2'b00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 8'hFF);
        idle("R6");
        // R7: write 0 without a fresh read does nothing
        step("R7", 2'b00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 8'h00);
        idle("R7");
        // R7: read (bit1=0), bit1 set later, write 0 -> bit1 stays, bit0 cleared
        step("R7", 2'b00, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 8'h00);
        step("R7", 2'b00, 4'h2, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00);
        step("R7", 2'b00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 8'h00);
        idle("R7");
        // R4: compare/pwm modes, edges ignored
        step("R4", 2'b10, 4'hF, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00);
        idle("R4");
        step("R4", 2'b11, 4'h0, 4'h8, 1'b0, 1'b0, 1'b0, 8'h00);
        idle("R4");
        // R8: set coincides with qualifying clear
        step("R8", 2'b01, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 8'h00);
        step("R8", 2'b01, 4'h0, 4'h8, 1'b0, 1'b0, 1'b1, 8'h00);
        idle("R8");
        // R9: read and write together use older markers
        step("R9", 2'b01, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 8'h00);
        step("R9", 2'b01, 4'h0, 4'h1, 1'b0, 1'b1, 1'b1, 8'h00);
        step("R9", 2'b01, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 8'h00);
        idle("R9");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic rd, we;
            rd = ($urandom % 3) == 0;
            we = ($urandom % 3) == 0;
            step("R3 R4 R5 R6 R7 R8 R9", 2'($urandom), 4'($urandom & $urandom),
                 4'($urandom & $urandom), (($urandom % 6) == 0), rd, we, 8'($urandom));
            if (($urandom % 400) == 0) begin
                rst = 1'b1;
                step("R1", 2'b00, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 8'h00);
                rst = 1'b0;
                idle("R1");
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule